// File: doc/BRIEF.md
# Dual 8-bit compare timer with cascade

Two 8-bit counting channels share one byte-wide register bus. Each channel has a count register, two compare registers (A and B), an interrupt/clear control register, a status byte and a clock-select register. A shared free-running prescaler sets the rate of each channel from the input clock. On a compare hit or a wrap the channel raises a one-cycle interrupt pulse, if the matching enable bit is set. The control register can also make the counter restart from zero when it reaches compare A or compare B.

The two channels can be joined in two ways. With the cascade bit set in channel 0's clock-select register, the pair acts as one 16-bit counter. Channel 0 holds the high byte and channel 1 the low byte, and the compare registers are paired the same way. With the cascade bit set only in channel 1, channel 1 counts the compare-A hits of channel 0. The status bytes are plain storage: they hold bits for output pins and converter triggers that this block does not drive.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, every count and control register reads 0x00. Every compare register reads 0xFF. Both clock-select registers read 0x00. The channel 0 status byte reads 0x00 and the channel 1 status byte reads 0x10.
- R2: Clock-select bits [2:0] pick the rate. Codes 1 to 7 advance the counter once every 1, 2, 8, 32, 64, 1024 and 8192 input clocks. Code 0, with the cascade bit (bit 3) clear, holds the counter.
- R3: A counter in free-run steps 0x00 through 0xFF. On the step from 0xFF to 0x00 it pulses its overflow interrupt, provided control bit 2 is set.
- R4: Control bits [4:3] select the clear mode. Value 01 restarts the count at 0 on the step that would reach compare A, and value 10 does the same for compare B. With a compare value c the counter therefore repeats every c steps. Values 00 and 11 leave the counter free-running.
- R5: A step whose new value equals compare A pulses interrupt A if control bit 0 is set. A step whose new value equals compare B pulses interrupt B if control bit 1 is set. When both compares are hit in one step, both pulses are raised, and only the compare chosen by the clear mode clears the counter.
- R6: Each interrupt output is a registered pulse. It is high for one cycle per hit, in the cycle the counter shows the stepped value.
- R7: In 16-bit mode, set by clock-select bit 3 of channel 0, the counter is {count0, count1}. It runs at the rate of channel 1's clock-select code, with carry from the low byte into the high byte. It compares against {cmpA0, cmpA1} and {cmpB0, cmpB1} and wraps at 0x10000. Channel 0's control register governs it and reports on the index-0 interrupt outputs. The index-1 outputs stay low.
- R8: When bit 3 is set in channel 1's clock-select register but not in channel 0's, count1 rises by one for every compare-A hit of channel 0, whatever the interrupt enables.
- R9: The bus address is {index[2:0], channel}. The indexes are 0 control, 1 status, 2 compare A, 3 compare B, 4 count and 5 clock-select. A byte read returns the register in rdata[7:0] with zeros above it, one cycle after the read strobe. Indexes 6 and 7 read as zero.
- R10: A wide access is legal at a channel-0 address with index 2 to 5. A wide write stores wdata[15:8] in channel 0 and wdata[7:0] in channel 1. A wide read returns {channel0, channel1}.
- R11: A wide access at an odd address, or at index 0 or 1, reads as zero, and its write changes no register.
- R12: A bus write to a count register sets the value seen after that clock edge. It overrides any step that the counter would have taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address {index, channel} |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wide | input | 1 | Access is 16 bits wide |
| bus_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| bus_rdata | output | 16 | Registered read data |
| irq_cmp_a | output | 2 | Compare-A interrupt pulse per channel |
| irq_cmp_b | output | 2 | Compare-B interrupt pulse per channel |
| irq_ovf | output | 2 | Overflow interrupt pulse per channel |

## Verification
The assertions assume that the bus carries at most one access per cycle. The stopped-counter property also assumes that nothing writes while a channel's clock-select byte is zero. The bench drives each access for exactly one cycle and keeps its idle waits free of writes. Counts are measured over windows that are whole multiples of the step period, or of the prescaler period. The expected results therefore hold whatever the phase of the prescaler when a window opens.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W   = 4;
  localparam int CODE_W   = 3;

  // register index, bits [3:1] of the bus address
  localparam logic [2:0] RG_CTRL = 3'd0;
  localparam logic [2:0] RG_STAT = 3'd1;
  localparam logic [2:0] RG_CMPA = 3'd2;
  localparam logic [2:0] RG_CMPB = 3'd3;
  localparam logic [2:0] RG_CNT  = 3'd4;
  localparam logic [2:0] RG_CSEL = 3'd5;

  // control byte fields
  localparam int IE_A_BIT   = 0;
  localparam int IE_B_BIT   = 1;
  localparam int IE_OVF_BIT = 2;
  localparam int CLR_LSB    = 3;

  // clock-select byte: code in [2:0], cascade flag in bit 3
  localparam int CAS_BIT = 3;

  localparam logic [1:0] CLR_ON_A = 2'b01;
  localparam logic [1:0] CLR_ON_B = 2'b10;

  // log2 of the divide ratio for each clock-select code
  function automatic int div_shift(input int code);
    case (code)
      1: return 0;
      2: return 1;
      3: return 3;
      4: return 5;
      5: return 6;
      6: return 10;
      default: return 13;
    endcase
  endfunction

  localparam int PRE_W = div_shift(7);
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  output logic [2**CODE_W-1:0]  tick_by_code
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  assign tick_by_code[0] = 1'b0;

  for (genvar k = 1; k < 2**CODE_W; k++) begin : g_code
    localparam int SH = div_shift(k);
    localparam logic [PRE_W-1:0] MASK = PRE_W'((64'd1 << SH) - 64'd1);
    assign tick_by_code[k] = ((pre_q & MASK) == MASK);
  end
endmodule

// File: rtl/tmr_step.sv
module tmr_step
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic [1:0]   clr_mode,
  output logic [W-1:0] nxt,
  output logic         hit_a,
  output logic         hit_b,
  output logic         wrap
);
  logic [W:0] inc;
  logic       restart;

  always_comb begin
    inc     = {1'b0, cnt} + (W+1)'(1);
    hit_a   = tick && (inc[W-1:0] == cmp_a);
    hit_b   = tick && (inc[W-1:0] == cmp_b);
    wrap    = tick && inc[W];
    restart = ((clr_mode == CLR_ON_A) && hit_a) || ((clr_mode == CLR_ON_B) && hit_b);
    if (!tick)        nxt = cnt;
    else if (restart) nxt = '0;
    else              nxt = inc[W-1:0];
  end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import tmr_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_wide,
  input  logic [2*CW-1:0]   bus_wdata,
  output logic [2*CW-1:0]   bus_rdata,
  output logic [1:0]        irq_cmp_a,
  output logic [1:0]        irq_cmp_b,
  output logic [1:0]        irq_ovf
);
  localparam int NCH = 2;
  localparam int DW  = 2*CW;

  logic [CW-1:0] ctrl_q [NCH];
  logic [CW-1:0] stat_q [NCH];
  logic [CW-1:0] cmpa_q [NCH];
  logic [CW-1:0] cmpb_q [NCH];
  logic [CW-1:0] cnt_q  [NCH];
  logic [CW-1:0] csel_q [NCH];

  // ---------------- bus decode ----------------
  logic [2:0]    idx;
  logic          sel_ch;
  logic          wide_ok;
  logic [NCH-1:0] wsel;
  logic [CW-1:0] wbyte [NCH];

  assign idx     = bus_addr[3:1];
  assign sel_ch  = bus_addr[0];
  assign wide_ok = !sel_ch && (idx >= RG_CMPA) && (idx <= RG_CSEL);

  always_comb begin
    wsel     = '0;
    wbyte[0] = bus_wdata[CW-1:0];
    wbyte[1] = bus_wdata[CW-1:0];
    if (bus_wr) begin
      if (bus_wide) begin
        if (wide_ok) begin
          wsel     = '1;
          wbyte[0] = bus_wdata[DW-1:CW];
          wbyte[1] = bus_wdata[CW-1:0];
        end
      end else begin
        wsel[sel_ch] = 1'b1;
      end
    end
  end

  // ---------------- count sources ----------------
  logic [2**CODE_W-1:0] tick_by_code;
  logic cas16, evt1;
  logic tick0, tick1, tick16;

  tmr_prescaler u_pre (
    .clk          (clk),
    .rst          (rst),
    .tick_by_code (tick_by_code)
  );

  assign cas16 = csel_q[0][CAS_BIT];
  assign evt1  = csel_q[1][CAS_BIT] && !cas16;

  logic [CW-1:0] nxt0, nxt1;
  logic [DW-1:0] nxt16;
  logic h0a, h0b, w0, h1a, h1b, w1, h16a, h16b, w16;

  assign tick0  = !cas16 && tick_by_code[csel_q[0][CODE_W-1:0]];
  assign tick1  = evt1 ? h0a : (!cas16 && tick_by_code[csel_q[1][CODE_W-1:0]]);
  assign tick16 = cas16 && tick_by_code[csel_q[1][CODE_W-1:0]];

  tmr_step #(.W(CW)) u_step0 (
    .tick (tick0), .cnt (cnt_q[0]), .cmp_a (cmpa_q[0]), .cmp_b (cmpb_q[0]),
    .clr_mode (ctrl_q[0][CLR_LSB +: 2]),
    .nxt (nxt0), .hit_a (h0a), .hit_b (h0b), .wrap (w0)
  );

  tmr_step #(.W(CW)) u_step1 (
    .tick (tick1), .cnt (cnt_q[1]), .cmp_a (cmpa_q[1]), .cmp_b (cmpb_q[1]),
    .clr_mode (ctrl_q[1][CLR_LSB +: 2]),
    .nxt (nxt1), .hit_a (h1a), .hit_b (h1b), .wrap (w1)
  );

  tmr_step #(.W(DW)) u_step16 (
    .tick (tick16), .cnt ({cnt_q[0], cnt_q[1]}),
    .cmp_a ({cmpa_q[0], cmpa_q[1]}), .cmp_b ({cmpb_q[0], cmpb_q[1]}),
    .clr_mode (ctrl_q[0][CLR_LSB +: 2]),
    .nxt (nxt16), .hit_a (h16a), .hit_b (h16b), .wrap (w16)
  );

  logic [CW-1:0] cnt_nxt [NCH];
  assign cnt_nxt[0] = cas16 ? nxt16[DW-1:CW] : nxt0;
  assign cnt_nxt[1] = cas16 ? nxt16[CW-1:0]  : nxt1;

  // ---------------- register banks ----------------
  for (genvar c = 0; c < NCH; c++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[c] <= '0;
        stat_q[c] <= CW'(c == 1 ? 16 : 0);
        cmpa_q[c] <= '1;
        cmpb_q[c] <= '1;
        cnt_q[c]  <= '0;
        csel_q[c] <= '0;
      end else begin
        if (wsel[c] && idx == RG_CTRL) ctrl_q[c] <= wbyte[c];
        if (wsel[c] && idx == RG_STAT) stat_q[c] <= wbyte[c];
        if (wsel[c] && idx == RG_CMPA) cmpa_q[c] <= wbyte[c];
        if (wsel[c] && idx == RG_CMPB) cmpb_q[c] <= wbyte[c];
        if (wsel[c] && idx == RG_CSEL) csel_q[c] <= wbyte[c];
        cnt_q[c] <= (wsel[c] && idx == RG_CNT) ? wbyte[c] : cnt_nxt[c];
      end
    end
  end

  // ---------------- interrupt pulses ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_cmp_a <= '0;
      irq_cmp_b <= '0;
      irq_ovf   <= '0;
    end else begin
      irq_cmp_a[0] <= ctrl_q[0][IE_A_BIT]   && (cas16 ? h16a : h0a);
      irq_cmp_b[0] <= ctrl_q[0][IE_B_BIT]   && (cas16 ? h16b : h0b);
      irq_ovf[0]   <= ctrl_q[0][IE_OVF_BIT] && (cas16 ? w16  : w0);
      irq_cmp_a[1] <= ctrl_q[1][IE_A_BIT]   && !cas16 && h1a;
      irq_cmp_b[1] <= ctrl_q[1][IE_B_BIT]   && !cas16 && h1b;
      irq_ovf[1]   <= ctrl_q[1][IE_OVF_BIT] && !cas16 && w1;
    end
  end

  // ---------------- read port ----------------
  logic [CW-1:0] rbyte [NCH];
  for (genvar c = 0; c < NCH; c++) begin : g_rd
    always_comb begin
      case (idx)
        RG_CTRL: rbyte[c] = ctrl_q[c];
        RG_STAT: rbyte[c] = stat_q[c];
        RG_CMPA: rbyte[c] = cmpa_q[c];
        RG_CMPB: rbyte[c] = cmpb_q[c];
        RG_CNT:  rbyte[c] = cnt_q[c];
        RG_CSEL: rbyte[c] = csel_q[c];
        default: rbyte[c] = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_wide) bus_rdata <= wide_ok ? {rbyte[0], rbyte[1]} : '0;
      else          bus_rdata <= {{CW{1'b0}}, rbyte[sel_ch]};
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int CW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_wide,
  input logic [2*CW-1:0]   bus_rdata,
  input logic [1:0]        irq_cmp_a,
  input logic [1:0]        irq_cmp_b,
  input logic [1:0]        irq_ovf,
  input logic [CW-1:0]     cnt0,
  input logic [CW-1:0]     cnt1,
  input logic [CW-1:0]     ctrl0,
  input logic [CW-1:0]     csel0,
  input logic [CW-1:0]     cmpa0,
  input logic [CW-1:0]     stat1
);
  logic cas16;
  assign cas16 = csel0[CAS_BIT];

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cnt0 == '0 && cnt1 == '0 && csel0 == '0 && cmpa0 == '1 && stat1 == CW'(16)));

  assert_stopped_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr && csel0 == '0) |=> (cnt0 == $past(cnt0)));

  assert_ovf_from_top_R3: assert property (@(posedge clk) disable iff (rst)
    irq_ovf[0] |-> $past(cas16 ? ({cnt0, cnt1} == '1) : (cnt0 == '1)));

  assert_irq_a_gated_R5: assert property (@(posedge clk) disable iff (rst)
    irq_cmp_a[0] |-> $past(ctrl0[IE_A_BIT]));

  assert_irq_b_gated_R5: assert property (@(posedge clk) disable iff (rst)
    irq_cmp_b[0] |-> $past(ctrl0[IE_B_BIT]));

  assert_pair_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    cas16 |=> (irq_cmp_a[1] == 1'b0 && irq_cmp_b[1] == 1'b0 && irq_ovf[1] == 1'b0));

  assert_bad_wide_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_wide && bus_addr[0]) |=> (bus_rdata == '0));
endmodule

bind dual_cmp_timer tmr_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wide  (bus_wide),
  .bus_rdata (bus_rdata),
  .irq_cmp_a (irq_cmp_a),
  .irq_cmp_b (irq_cmp_b),
  .irq_ovf   (irq_ovf),
  .cnt0      (cnt_q[0]),
  .cnt1      (cnt_q[1]),
  .ctrl0     (ctrl_q[0]),
  .csel0     (csel_q[0]),
  .cmpa0     (cmpa_q[0]),
  .stat1     (stat_q[1])
);

// File: tb/dual_cmp_timer_bench.sv
module dual_cmp_timer_bench;
  localparam int I_CTRL = 0, I_STAT = 1, I_CMPA = 2, I_CMPB = 3, I_CNT = 4, I_CSEL = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, wide = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  irq_a, irq_b, irq_o;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  bit clr_win = 1'b0;
  int pa [2];
  int pb [2];
  int po [2];

  always #5 clk = ~clk;

  dual_cmp_timer u_dual_cmp_timer (
    .clk (clk), .rst (rst), .bus_addr (addr), .bus_wr (wr), .bus_rd (rd),
    .bus_wide (wide), .bus_wdata (wdata), .bus_rdata (rdata),
    .irq_cmp_a (irq_a), .irq_cmp_b (irq_b), .irq_ovf (irq_o)
  );

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (clr_win) begin
        pa[k] = 0; pb[k] = 0; po[k] = 0;
      end else begin
        pa[k] = pa[k] + int'(irq_a[k]);
        pb[k] = pb[k] + int'(irq_b[k]);
        po[k] = po[k] + int'(irq_o[k]);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_raw(input int a, input bit w, input int val);
    @(negedge clk);
    addr = 4'(a); wide = w; wdata = 16'(val); wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wide = 1'b0;
  endtask

  task automatic rd_raw(input int a, input bit w, output int val);
    @(negedge clk);
    addr = 4'(a); wide = w; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0; wide = 1'b0;
    val = int'(rdata);
  endtask

  task automatic wr8(input int i, input int ch, input int val);
    wr_raw(i*2 + ch, 1'b0, val);
  endtask

  task automatic wr16(input int i, input int val);
    wr_raw(i*2, 1'b1, val);
  endtask

  task automatic rd8(input int i, input int ch, output int val);
    rd_raw(i*2 + ch, 1'b0, val);
  endtask

  task automatic rd16(input int i, output int val);
    rd_raw(i*2, 1'b1, val);
  endtask

  task automatic window(input int n);
    @(negedge clk); clr_win = 1'b1;
    @(negedge clk); clr_win = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int v;
    int rst_exp [6];
    int codes_div [8];
    int clr_vals [4];
    rst_exp = '{0, 0, 'hFF, 'hFF, 0, 0};
    codes_div = '{0, 1, 2, 8, 32, 64, 1024, 8192};
    clr_vals = '{1, 5, 37, 200};

    // R1: reset values
    do_reset();
    for (int i = 0; i < 6; i++) begin
      for (int ch = 0; ch < 2; ch++) begin
        rd8(i, ch, v);
        check("R1", v, (i == I_STAT && ch == 1) ? 'h10 : rst_exp[i]);
      end
    end

    // R9: byte write/readback of every register, upper byte zero
    for (int i = 0; i < 6; i++) begin
      for (int ch = 0; ch < 2; ch++) begin
        int pat;
        pat = (i == I_CSEL) ? ('hF0 | (ch << 6)) : ((i + 1) * 'h11 + ch * 'h80) & 'hFF;
        wr8(i, ch, pat);
        rd8(i, ch, v);
        check("R9", v, pat);
      end
    end
    rd_raw(12, 1'b0, v);
    check("R9 unused index", v, 0);

    // R10: wide write splits bytes, wide read joins them
    wr16(I_CMPB, 'hBEEF);
    rd8(I_CMPB, 0, v); check("R10 high byte", v, 'hBE);
    rd8(I_CMPB, 1, v); check("R10 low byte", v, 'hEF);
    rd16(I_CMPB, v);   check("R10 wide read", v, 'hBEEF);

    // R11: illegal wide accesses
    wr_raw(I_CMPB*2 + 1, 1'b1, 'h1234);
    rd16(I_CMPB, v);   check("R11 odd wide write ignored", v, 'hBEEF);
    wr_raw(I_CTRL*2, 1'b1, 'h7777);
    rd8(I_CTRL, 0, v); check("R11 ctrl wide write ignored", v, 'h11);
    rd8(I_CTRL, 1, v); check("R11 ctrl wide write ignored ch1", v, 'h91);
    rd_raw(I_CTRL*2, 1'b1, v);      check("R11 ctrl wide read", v, 0);
    rd_raw(I_CMPB*2 + 1, 1'b1, v);  check("R11 odd wide read", v, 0);

    // R2: every divider code, three steps per window
    do_reset();
    for (int code = 1; code < 8; code++) begin
      wr8(I_CSEL, 0, code);
      wr8(I_CNT, 0, 0);
      repeat (3 * codes_div[code] - 1) @(negedge clk);
      rd8(I_CNT, 0, v);
      check($sformatf("R2 code %0d", code), v, 3);
    end
    wr8(I_CSEL, 0, 0);
    wr8(I_CNT, 0, 'h40);
    repeat (50) @(negedge clk);
    rd8(I_CNT, 0, v);
    check("R2 code 0 holds", v, 'h40);

    // R12: write overrides the step of the same cycle
    wr8(I_CSEL, 0, 1);
    wr8(I_CNT, 0, 'h80);
    rd8(I_CNT, 0, v);
    check("R12 write wins", v, 'h81);

    // R3 / R6: free-run overflow, one pulse per wrap
    do_reset();
    wr8(I_CTRL, 0, 'h04);
    wr8(I_CSEL, 0, 1);
    wr8(I_CNT, 0, 0);
    window(1024);
    check("R3 ch0 overflow pulses", po[0], 4);
    check("R3 ch1 idle", po[1], 0);
    wr8(I_CTRL, 0, 'h00);
    window(512);
    check("R5 overflow disabled", po[0], 0);
    wr8(I_CSEL, 0, 0);
    wr8(I_CTRL, 1, 'h04);
    wr8(I_CSEL, 1, 2);
    wr8(I_CNT, 1, 0);
    window(1024);
    check("R3 ch1 div2 overflow pulses", po[1], 2);

    // R4 / R5: clear on compare A sweep
    for (int n = 0; n < 4; n++) begin
      int c;
      c = clr_vals[n];
      do_reset();
      wr8(I_CTRL, 0, 'h07 | (1 << 3));
      wr8(I_CMPA, 0, c);
      wr8(I_CMPB, 0, c / 2);
      wr8(I_CSEL, 0, 1);
      wr8(I_CNT, 0, 0);
      window(4 * c);
      check($sformatf("R4 clear on A c=%0d", c), pa[0], 4);
      check($sformatf("R5 B inside period c=%0d", c), pb[0], (c >= 2) ? 4 : 0);
      check($sformatf("R4 no overflow c=%0d", c), po[0], 0);
    end

    // R4: clear on compare B
    do_reset();
    wr8(I_CTRL, 0, 'h03 | (2 << 3));
    wr8(I_CMPA, 0, 30);
    wr8(I_CMPB, 0, 20);
    wr8(I_CSEL, 0, 1);
    wr8(I_CNT, 0, 0);
    window(80);
    check("R4 clear on B pulses", pb[0], 4);
    check("R4 A beyond B never hit", pa[0], 0);

    // R5: both compares equal, both reported
    wr8(I_CMPA, 0, 25);
    wr8(I_CMPB, 0, 25);
    wr8(I_CNT, 0, 0);
    window(100);
    check("R5 dual hit A", pa[0], 4);
    check("R5 dual hit B", pb[0], 4);

    // R4: mode 11 free-runs
    wr8(I_CTRL, 0, 'h07 | (3 << 3));
    wr8(I_CMPA, 0, 'h10);
    wr8(I_CNT, 0, 0);
    window(512);
    check("R4 mode 3 A pulses", pa[0], 2);
    check("R4 mode 3 overflow", po[0], 2);

    // R7: 16-bit mode
    do_reset();
    wr8(I_CTRL, 0, 'h04);
    wr8(I_CTRL, 1, 'h07);
    wr8(I_CSEL, 1, 1);
    wr8(I_CSEL, 0, 'h08);
    wr16(I_CNT, 'h00FD);
    repeat (3) @(negedge clk);
    rd16(I_CNT, v);
    check("R7 carry into high byte", v, 'h0101);
    wr16(I_CNT, 'hFFF0);
    window(40);
    check("R7 16-bit overflow", po[0], 1);
    check("R7 ch1 overflow silent", po[1], 0);
    wr8(I_CTRL, 0, 'h01 | (1 << 3));
    wr16(I_CMPA, 'h012C);
    wr16(I_CNT, 0);
    window(900);
    check("R7 16-bit compare A", pa[0], 3);
    check("R7 ch1 compare silent", pa[1], 0);

    // R8: channel 1 counts channel 0 compare-A hits
    do_reset();
    wr8(I_CMPA, 0, 10);
    wr8(I_CTRL, 0, 1 << 3);
    wr8(I_CSEL, 1, 'h08);
    wr8(I_CSEL, 0, 1);
    wr16(I_CNT, 0);
    repeat (69) @(negedge clk);
    rd8(I_CNT, 1, v);
    check("R8 event count", v, 7);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule